// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A character is offered with a valid/ready handshake. When the transmitter is idle it takes the character and a snapshot of the format fields from the control word. It then drives a low start bit, the data bits least significant first, an optional parity bit and the stop period. It then returns to the high idle level. Timing comes from an enable tick that runs at sixteen times the baud rate, and every bit lasts sixteen ticks.

The control word selects 5 to 8 data bits, a short or long stop period, and parity. Parity can be odd, even, or held at a fixed level. One extra control bit forces the line low at once to send a break. That bit is read live and is not part of the snapshot. The frame underneath keeps running while the break is held, so the busy flag falls at its normal time.

Top module: `uart_tx_frame`

## Requirements
- R1: The line sends a start bit of 0 and then the data bits, least significant first. The number of data bits comes from control bits [1:0]: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length are not sent.
- R2: When control bit 2 is 0, the stop period is one bit long (16 ticks) at every word length.
- R3: When control bit 2 is 1, the stop period is 24 ticks (one and a half bits) for 5-bit characters and 32 ticks (two bits) for 6-, 7- and 8-bit characters.
- R4: When control bit 3 is 1, one parity bit is sent after the last data bit and before the stop period. When control bit 3 is 0, no parity bit is sent.
- R5: With parity enabled and control bit 5 at 0, control bit 4 picks the parity sense. A 0 makes the number of ones across the data bits and the parity bit odd, and a 1 makes it even.
- R6: With control bits 3 and 5 both at 1, the parity bit is fixed at the inverse of control bit 4 and does not depend on the data.
- R7: While control bit 6 is 1, txd is 0 in the same cycle, both when idle and during a frame. txd stays 0 until the bit is cleared.
- R8: Every start, data and parity bit lasts exactly 16 ticks of tick16. Cycles without a tick do not advance the frame.
- R9: When idle, txd is 1 and in_ready is 1. The cycle after a character is accepted, busy rises. It stays high until the stop period ends, and in_ready is 0 for that whole time.
- R10: The format fields and the data are captured when the character is accepted. Changes to in_data or to control bits [5:0] during a frame do not change that frame.
- R11: A break held during a frame does not stop the frame. busy falls at the same tick it would fall without the break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at sixteen times the baud rate |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | The transmitter is idle and can accept a character |
| in_data | input | 8 | Character to send; only the low bits up to the word length are sent |
| ctl_word | input | 7 | Bits [1:0] word length, [2] long stop, [3] parity on, [4] even sense, [5] fixed parity, [6] break |
| txd | output | 1 | Serial output, high when idle |
| busy | output | 1 | A frame is in progress |

## Verification
If the bit index or the phase state is wrong, the fault shows on txd within the next bit period. A data bit that is out of place or missing moves every later bit, so the parity and stop positions sampled afterwards are wrong. If the tick counter or the stop-length choice is wrong, busy falls at the wrong tick. The bench compares the fall of busy against the tick it predicts for each format. If the configuration snapshot is missing, the error shows within the first data bit, because the bench changes the control word and the data just after the handshake. A break that leaks into the sequencer changes when busy falls.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int MAX_BITS = 8;
  localparam int CTL_W    = 7;
  localparam int BRK_BIT  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // Packed so that ctl_word[5:0] maps straight onto it.
  typedef struct packed {
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop_ext;
    logic [1:0] wlen;
  } frame_cfg_t;

  function automatic int data_bits(input logic [1:0] w);
    return 5 + int'(w);
  endfunction

  // The stop period is counted in ticks, so the half bit needs no extra state.
  function automatic int stop_ticks(input frame_cfg_t c, input int tpb);
    if (!c.stop_ext)
      return tpb;
    if (c.wlen == 2'b00)
      return tpb + tpb / 2;
    return 2 * tpb;
  endfunction

  function automatic logic parity_bit(input frame_cfg_t c,
                                      input logic [MAX_BITS-1:0] d);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < MAX_BITS; i++)
      if (i < data_bits(c.wlen))
        acc = acc ^ d[i];
    if (c.stick)
      return ~c.even;
    return c.even ? acc : ~acc;
  endfunction

endpackage

// File: rtl/uart_tx_tickcnt.sv
module uart_tx_tickcnt #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  assign done = tick && (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr || done)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int TPB = 16,
  parameter int CW  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [MAX_BITS-1:0] in_data,
  input  frame_cfg_t          cfg_in,
  input  logic                phase_done,
  output logic                in_ready,
  output logic                frame_start,
  output logic                busy,
  output logic                ser_bit,
  output logic [CW-1:0]       limit
);

  localparam int IW = $clog2(MAX_BITS);

  tx_state_e           state_q;
  frame_cfg_t          cfg_q;
  logic [MAX_BITS-1:0] shreg_q;
  logic [IW-1:0]       idx_q;
  logic                par_q;
  logic                last_data;

  assign in_ready    = (state_q == ST_IDLE);
  assign frame_start = in_ready && in_valid;
  assign busy        = (state_q != ST_IDLE);
  assign last_data   = (int'(idx_q) == data_bits(cfg_q.wlen) - 1);

  always_comb begin
    limit = CW'(TPB);
    if (state_q == ST_STOP)
      limit = CW'(stop_ticks(cfg_q, TPB));
  end

  always_comb begin
    unique case (state_q)
      ST_START: ser_bit = 1'b0;
      ST_DATA:  ser_bit = shreg_q[0];
      ST_PAR:   ser_bit = par_q;
      default:  ser_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      shreg_q <= '0;
      idx_q   <= '0;
      par_q   <= 1'b0;
    end else if (frame_start) begin
      state_q <= ST_START;
      cfg_q   <= cfg_in;
      shreg_q <= in_data;
      idx_q   <= '0;
      par_q   <= parity_bit(cfg_in, in_data);
    end else if (phase_done) begin
      unique case (state_q)
        ST_START: state_q <= ST_DATA;
        ST_DATA: begin
          shreg_q <= shreg_q >> 1;
          idx_q   <= idx_q + IW'(1);
          if (last_data)
            state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR:  state_q <= ST_STOP;
        ST_STOP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line (
  input  logic ser_bit,
  input  logic brk,
  output logic txd
);

  // The break gate comes after the sequencer and is not registered, so it takes effect in the same cycle.
  assign txd = ser_bit && !brk;

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick16,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MAX_BITS-1:0] in_data,
  input  logic [CTL_W-1:0]    ctl_word,
  output logic                txd,
  output logic                busy
);

  localparam int CW = $clog2(2 * TICKS_PER_BIT + 1);

  frame_cfg_t    cfg_live;
  logic          brk;
  logic          frame_start;
  logic          phase_done;
  logic          ser_bit;
  logic [CW-1:0] limit;

  assign cfg_live = frame_cfg_t'(ctl_word[5:0]);
  assign brk      = ctl_word[BRK_BIT];

  uart_tx_tickcnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (frame_start),
    .tick  (tick16),
    .limit (limit),
    .done  (phase_done)
  );

  uart_tx_seq #(.TPB(TICKS_PER_BIT), .CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .cfg_in      (cfg_live),
    .phase_done  (phase_done),
    .in_ready    (in_ready),
    .frame_start (frame_start),
    .busy        (busy),
    .ser_bit     (ser_bit),
    .limit       (limit)
  );

  uart_tx_line u_line (
    .ser_bit (ser_bit),
    .brk     (brk),
    .txd     (txd)
  );

endmodule

// File: rtl/uart_tx_frame_chk.sv
module uart_tx_frame_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic busy,
  input logic brk,
  input logic ser_bit,
  input logic frame_start
);

  a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> txd);

  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!ser_bit && busy));

  a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick16 && !frame_start) |=> ($stable(ser_bit) && $stable(busy)));

  a_r11_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick16));

endmodule

bind uart_tx_frame uart_tx_frame_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick16      (tick16),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .txd         (txd),
  .busy        (busy),
  .brk         (brk),
  .ser_bit     (ser_bit),
  .frame_start (frame_start)
);

// File: tb/uart_tx_frame_bench.sv
`timescale 1ns/1ps
module uart_tx_frame_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [6:0] ctl_word = 7'h00;
  logic       in_ready, txd, busy;
  int         checks = 0;
  int         failures = 0;

  always #10 clk = ~clk;

  uart_tx_frame u_uart_tx_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick16   (tick16),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .ctl_word (ctl_word),
    .txd      (txd),
    .busy     (busy)
  );

  // {ctl[5:0], data}; ctl: [5] fixed parity, [4] even, [3] parity on, [2] long stop, [1:0] length
  localparam logic [13:0] VEC [8] = '{
    {6'b000000, 8'hB5},  // R1 R2: 5 bits, one stop, no parity
    {6'b000100, 8'h0A},  // R3: 5 bits, 1.5 stop
    {6'b001101, 8'h2C},  // R3 R4 R5: 6 bits odd, 2 stop
    {6'b011010, 8'h5B},  // R4 R5: 7 bits even
    {6'b001111, 8'hA7},  // R5: 8 bits odd, 2 stop
    {6'b111011, 8'hFF},  // R6: fixed parity 0
    {6'b101010, 8'h00},  // R6: fixed parity 1
    {6'b000011, 8'h81}   // R1 R2: 8 bits plain
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [5:0] c);
    return 5 + int'(c[1:0]);
  endfunction

  function automatic logic exp_par(input logic [5:0] c, input logic [7:0] d);
    int ones;
    ones = 0;
    for (int i = 0; i < nbits(c); i++)
      if (d[i]) ones++;
    if (c[5]) return ~c[4];
    if (c[4]) return logic'(ones % 2);
    return logic'(1 - ones % 2);
  endfunction

  function automatic int stop_len(input logic [5:0] c);
    if (!c[2]) return 16;
    if (c[1:0] == 2'b00) return 24;
    return 32;
  endfunction

  function automatic logic exp_bit(input logic [5:0] c, input logic [7:0] d, input int idx);
    if (idx == 0) return 1'b0;
    if (idx <= nbits(c)) return d[idx-1];
    if (c[3] && idx == nbits(c) + 1) return exp_par(c, d);
    return 1'b1;
  endfunction

  // Sends one frame, driving each tick itself and comparing txd and busy between ticks.
  task automatic run_frame(input logic [7:0] d, input logic [5:0] c,
                           input int brk_from, input int brk_to);
    int  total, bad_n;
    bit  bad;
    logic e, got;
    total = 16 * (1 + nbits(c) + int'(c[3])) + stop_len(c);
    bad = 0; bad_n = 0; e = 1'b0; got = 1'b0;
    @(negedge clk);
    in_data = d; ctl_word = {1'b0, c}; in_valid = 1'b1;
    #1 chk(in_ready === 1'b1, "R9 ready when idle", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    // R10: change data and format right after the handshake
    ctl_word = {1'b0, ~c}; in_data = ~d;
    for (int n = 0; n < total; n++) begin
      if (n == brk_from) ctl_word[6] = 1'b1;
      if (n == brk_to)   ctl_word[6] = 1'b0;
      #1;
      e = ctl_word[6] ? 1'b0 : exp_bit(c, d, n / 16);
      if (!bad && (txd !== e || busy !== 1'b1)) begin
        bad = 1; bad_n = n; got = txd;
      end
      if (n == 5)
        chk(in_ready === 1'b0, "R9 not ready while busy", in_ready, 0);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
      repeat (n % 3) @(negedge clk);  // R8: cycles without a tick must not move the frame
    end
    if (bad)
      $display("FAIL R1/R4/R5/R6/R8/R10 tick=%0d txd=%0d expected=%0d", bad_n, got, e);
    checks++;
    if (bad) failures++;
    ctl_word[6] = 1'b0;
    #1;
    chk(busy === 1'b0, "R2/R3/R11 busy ends after stop", busy, 0);
    chk(txd === 1'b1, "R9 idle high after frame", txd, 1);
  endtask

  initial begin
    #4_000_000;
    failures++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(txd === 1'b1, "R9 reset txd", txd, 1);
    chk(busy === 1'b0, "R9 reset busy", busy, 0);
    chk(in_ready === 1'b1, "R9 reset ready", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++)
      run_frame(VEC[v][7:0], VEC[v][13:8], -1, -1);

    // R7: break while idle is seen in the same cycle and released cleanly
    @(negedge clk);
    ctl_word[6] = 1'b1;
    #1 chk(txd === 1'b0, "R7 idle break", txd, 0);
    repeat (4) @(negedge clk);
    #1 chk(txd === 1'b0, "R7 break held", txd, 0);
    ctl_word[6] = 1'b0;
    #1 chk(txd === 1'b1, "R7 break released", txd, 1);

    // R7 R11: break during a frame; busy still falls on time
    run_frame(8'hFF, 6'b000011, 40, 100);
    run_frame(8'h55, 6'b011101, 10, 1000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule